// File: doc/BRIEF.md
# Module Power State Sequencer

This block moves a set of peripheral modules between four power/clock states. Software uses a small word-addressed register bus for every step. First it writes a requested state into each module's control register, which only stages that request. Then it writes a trigger bit in a domain command register. The sequencer captures every staged request at that moment and raises a busy flag. It holds that flag for a fixed, parameterised number of cycles, then commits all new states at once.

Each module has an enable output that stands in for its clock gate and power switch. The enable is high only in the enable state. Software polls the busy flag until it clears, then reads the per-module status register to confirm the state that was reached. Every transition takes a bounded time, so a polling loop with a fixed retry limit always terminates.

State encodings are 0 = software reset/disable, 1 = synchronous reset, 2 = disable, 3 = enable. Register word addresses are: 0x00 command (bit 0 = GO), 0x01 domain status (bit 0 = busy), 0x10+i control of module i, and 0x20+i status of module i.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset every module state is 0, every enable output is 0, the busy bit reads 0 and every control register reads 0.
- R2: A control register stores and reads back all DW bits written to it. Its bits [4:0] are the requested state, so a read-modify-write of bits [4:0] leaves the upper bits as they were.
- R3: Writing a control register without a GO changes no status field, no enable output and not the busy bit.
- R4: Writing 1 to bit 0 of address 0x00 while idle starts a transition; address 0x00 always reads 0.
- R5: When at least one module's valid requested state differs from its current state, bit 0 of address 0x01 reads 1 for exactly XFER_CYCLES cycles after the GO write and then reads 0.
- R6: While a transition runs, the enable outputs and the status fields keep their old values; both change together on the cycle busy clears.
- R7: After completion, bits [1:0] of address 0x20+i equal the state requested for module i (upper bits 0), and enable output i is 1 exactly when that state is 3.
- R8: A requested state of 4 to 31 is treated as no change: that module keeps its current state.
- R9: A GO written while busy is ignored and does not lengthen the transition.
- R10: A GO issued when no module needs a change raises busy for exactly one cycle and changes no state.
- R11: Requested states are captured at the GO; control writes during a transition do not alter the states it commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational on bus_addr |
| mod_en | output | NMOD | Per-module enable, 1 when the module is in state 3 |

## Verification
The hardest situation to reach is a bus access that lands in the middle of a running transition, either a second GO or a rewrite of a control register. The reference model in the bench must show that neither stretches the busy window nor changes the committed result. The bench issues a GO, lets a few cycles pass, and then drives the second access through the normal write task. It times the busy window with a free cycle counter. Each cycle in that window it also confirms that the enables and a status field still show the old state.

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl #(
  parameter int NMOD        = 4,
  parameter int DW          = 32,
  parameter int AW          = 8,
  parameter int XFER_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NMOD-1:0]   mod_en
);
  localparam int CW = $clog2(XFER_CYCLES + 1);
  localparam logic [AW-1:0] A_CMD  = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam int CTRL_BASE = 16;
  localparam int STAT_BASE = 32;

  logic [DW-1:0] ctrl_q [NMOD];
  logic [1:0]    cur_q  [NMOD];
  logic [1:0]    tgt_q  [NMOD];
  logic [1:0]    want   [NMOD];
  logic [NMOD-1:0] diff;
  logic          busy_q;
  logic [CW-1:0] cnt_q;

  wire wr_hit = bus_sel & bus_wr;
  wire go_req = wr_hit && bus_addr == A_CMD && bus_wdata[0] && !busy_q;
  wire finish = busy_q && cnt_q == '0;

  for (genvar i = 0; i < NMOD; i++) begin : g_mod
    assign want[i] = (ctrl_q[i][4:0] <= 5'd3) ? ctrl_q[i][1:0] : cur_q[i];
    assign diff[i] = want[i] != cur_q[i];
    assign mod_en[i] = cur_q[i] == 2'd3;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl_q[i] <= '0;
        cur_q[i]  <= 2'd0;
        tgt_q[i]  <= 2'd0;
      end else begin
        if (wr_hit && bus_addr == AW'(CTRL_BASE + i)) ctrl_q[i] <= bus_wdata;
        if (go_req) tgt_q[i] <= want[i];
        if (finish) cur_q[i] <= tgt_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (go_req) begin
      busy_q <= 1'b1;
      cnt_q  <= (|diff) ? CW'(XFER_CYCLES - 1) : '0;
    end else if (finish) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_STAT) bus_rdata[0] = busy_q;
    for (int i = 0; i < NMOD; i++) begin
      if (bus_addr == AW'(CTRL_BASE + i)) bus_rdata = ctrl_q[i];
      if (bus_addr == AW'(STAT_BASE + i)) bus_rdata[1:0] = cur_q[i];
    end
  end
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk #(
  parameter int NMOD        = 4,
  parameter int DW          = 32,
  parameter int AW          = 8,
  parameter int XFER_CYCLES = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic [DW-1:0]   bus_rdata,
  input logic [NMOD-1:0] mod_en
);
  int run_len;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) run_len <= 0;
    else run_len <= run_len + 1;
  end

  assert_busy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_len < XFER_CYCLES);

  assert_en_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(mod_en));

  assert_en_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mod_en) |-> $fell(busy));

  assert_go_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == AW'(0) |-> bus_rdata == '0);

  assert_busy_needs_go_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_sel && bus_wr && bus_addr == AW'(0) && bus_wdata[0]));
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk #(
  .NMOD(NMOD), .DW(DW), .AW(AW), .XFER_CYCLES(XFER_CYCLES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mod_en(mod_en)
);

// File: tb/pwr_state_ctrl_tb_top.sv
module pwr_state_ctrl_tb_top;
  localparam int NMOD = 4, DW = 32, AW = 8, XFER = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NMOD-1:0] mod_en;

  int checks = 0, errors = 0, cyc = 0;
  logic [DW-1:0] ctrl_m [NMOD];
  logic [1:0]    cur_m  [NMOD];
  logic [1:0]    pend_m [NMOD];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwr_state_ctrl #(.NMOD(NMOD), .DW(DW), .AW(AW), .XFER_CYCLES(XFER)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mod_en(mod_en));

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  function automatic logic [NMOD-1:0] en_model();
    logic [NMOD-1:0] e;
    for (int i = 0; i < NMOD; i++) e[i] = cur_m[i] == 2'd3;
    return e;
  endfunction

  task automatic set_ctrl(int i, logic [DW-1:0] v);
    bus_write(AW'(16 + i), v);
    ctrl_m[i] = v;
  endtask

  task automatic go(output int t0, output bit change);
    change = 0;
    for (int i = 0; i < NMOD; i++) begin
      pend_m[i] = (ctrl_m[i][4:0] <= 5'd3) ? ctrl_m[i][1:0] : cur_m[i];
      if (pend_m[i] != cur_m[i]) change = 1;
    end
    bus_write(AW'(0), 32'h1);
    t0 = cyc;
  endtask

  task automatic wait_idle(string req, int t0, output int len);
    logic [DW-1:0] d;
    logic [NMOD-1:0] e0 = en_model();
    len = -1;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      bus_read(AW'(1), d);
      if (d[0] == 1'b0) begin len = cyc - t0; break; end
      if (mod_en !== e0 || dut_i.mod_en !== e0) begin
        check({req, " R6 enable held"}, DW'(mod_en), DW'(e0));
      end
      bus_read(AW'(32), d);
      if (d !== DW'(cur_m[0])) check({req, " R6 status held"}, d, DW'(cur_m[0]));
    end
    for (int i = 0; i < NMOD; i++) cur_m[i] = pend_m[i];
  endtask

  task automatic check_all(string req);
    logic [DW-1:0] d;
    @(negedge clk);
    for (int i = 0; i < NMOD; i++) begin
      bus_read(AW'(32 + i), d);
      check({req, " status"}, d, DW'(cur_m[i]));
      bus_read(AW'(16 + i), d);
      check({req, " ctrl"}, d, ctrl_m[i]);
    end
    check({req, " enables"}, DW'(mod_en), DW'(en_model()));
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    @(negedge clk);
    bus_read(AW'(1), d);
    check("R1 busy", d, '0);
    check_all("R1");
  endtask

  task automatic t_stage_only();
    logic [DW-1:0] d;
    set_ctrl(0, 32'hABCD_E003);
    set_ctrl(1, 32'h1234_5601);
    repeat (3) @(negedge clk);
    bus_read(AW'(1), d);
    check("R3 busy after staging", d, '0);
    check_all("R3");
    bus_read(AW'(16), d);
    d = (d & ~32'h1F) | 32'h2;
    set_ctrl(0, d);
    @(negedge clk);
    bus_read(AW'(16), d);
    check("R2 rmw upper bits kept", d, 32'hABCD_E002);
    set_ctrl(0, 32'hABCD_E003);
  endtask

  task automatic t_go_change();
    int t0, len; bit ch; logic [DW-1:0] d;
    go(t0, ch);
    @(negedge clk);
    bus_read(AW'(0), d);
    check("R4 command reads zero", d, '0);
    wait_idle("R5", t0, len);
    check("R5 busy length", DW'(len), DW'(XFER));
    check_all("R7 after enable");
  endtask

  task automatic t_go_busy();
    int t0, len; bit ch;
    set_ctrl(2, 32'h3);
    go(t0, ch);
    repeat (4) @(negedge clk);
    bus_write(AW'(0), 32'h1);
    wait_idle("R9", t0, len);
    check("R9 GO while busy ignored", DW'(len), DW'(XFER));
    check_all("R9");
  endtask

  task automatic t_noop();
    int t0, len; bit ch;
    go(t0, ch);
    check("R10 model sees no change", DW'(ch), '0);
    wait_idle("R10", t0, len);
    check("R10 busy one cycle", DW'(len), 32'd1);
    check_all("R10");
  endtask

  task automatic t_invalid();
    int t0, len; bit ch;
    set_ctrl(3, 32'h0000_0007);
    set_ctrl(2, 32'h0000_001F);
    set_ctrl(0, 32'hABCD_E002);
    go(t0, ch);
    wait_idle("R8", t0, len);
    check("R8 busy length", DW'(len), DW'(XFER));
    check_all("R8 invalid request keeps state");
  endtask

  task automatic t_capture();
    int t0, len; bit ch; logic [DW-1:0] d;
    set_ctrl(1, 32'h3);
    go(t0, ch);
    repeat (3) @(negedge clk);
    set_ctrl(1, 32'h0);
    wait_idle("R11", t0, len);
    @(negedge clk);
    bus_read(AW'(33), d);
    check("R11 captured state committed", d, 32'd3);
    check_all("R11");
    go(t0, ch);
    wait_idle("R11 second", t0, len);
    check_all("R11 later GO applies new request");
  endtask

  initial begin
    for (int i = 0; i < NMOD; i++) begin ctrl_m[i] = '0; cur_m[i] = 2'd0; pend_m[i] = 2'd0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_stage_only();
    t_go_change();
    t_go_busy();
    t_noop();
    t_invalid();
    t_capture();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(100000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule